// File: doc/BRIEF.md
# Pin Function Select and Output Register Block

This block is the register front end of a general-purpose pin bank of up to 54 pins. Software reaches it over a simple word-addressed register bus. Through that bus it picks the role of each pin with a 3-bit function code, drives pin output values through write-one-to-set and write-one-to-clear words, and reads back the synchronised live pin levels.

Towards the pins the block produces three things for each pin: the output value, an output enable, and a decoded alternate-function index with a valid flag. An external pin multiplexer uses the index to route one of six alternate peripherals to the pad. The pads, the alternate peripherals and any event or interrupt logic sit outside the block.

The bus uses word addresses; each word is 32 bits. Register map by word address:

| Word address | Register |
|---|---|
| 0 to 5 | Function select words |
| 7, 8 | Set words for bank 0 and bank 1 |
| 10, 11 | Clear words for bank 0 and bank 1 |
| 13, 14 | Level words for bank 0 and bank 1 |

Pins 0 to 31 form bank 0 and pins 32 to 53 form bank 1. Bit *n* of a bank word belongs to pin 32·bank + *n*.

Top module: `gpio_pinmux_regs`

## Requirements
- R1: While `rstN` is low, and after it is released, every function field is 000, every pin output is 0, and `pinOe`, `pinAltValid`, `pinAltIdx` and `busRdData` are all zero.
- R2: Pin *p* has its 3-bit function field in select word *p*/10, at bits 3·(*p* mod 10) upward. A write to a select word updates all ten of its fields on the clock edge. A read of a select word returns the stored fields, with bits 31:30 reading 0. A read in the same cycle as a write returns the value before the write.
- R3: `pinOe[p]` is 1 exactly when the function field of pin *p* is 001.
- R4: Field values 100, 101, 110, 111, 011 and 010 set `pinAltValid[p]` and put alternate index 0, 1, 2, 3, 4 and 5 respectively on `pinAltIdx[3p+2:3p]`. Field values 000 and 001 give a valid flag of 0 and an index of 0.
- R5: Writing word 7 (bank 0) or word 8 (bank 1) sets the output of every pin whose bit is 1, from the next cycle. Pins whose bit is 0 keep their output.
- R6: Writing word 10 (bank 0) or word 11 (bank 1) clears the output of every pin whose bit is 1, from the next cycle. Pins whose bit is 0 keep their output.
- R7: Reads of words 7, 8, 10 and 11 return zero.
- R8: Each pin input passes through two flip-flops before it reaches the level words (13 for bank 0, 14 for bank 1). Read data is registered: `busRdData` shows the result in the cycle after `busRdEn` and holds it until the next read.
- R9: Fields of select word 5 above pin 53 and bits 31:22 of the bank 1 words read as zero. Set and clear bits for pins above 53 have no effect.
- R10: Word addresses 6, 9, 12 and 15 to 63 read as zero. Writes to them change no pin output, enable, alternate output or stored field.
- R11: A pin's output value is stored regardless of its function field. Changing the function field never changes the output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register word address |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe for one cycle |
| busRdData | output | 32 | Registered read data |
| pinIn | input | NUM_PINS | Raw pin input levels |
| pinOut | output | NUM_PINS | Pin output values |
| pinOe | output | NUM_PINS | Pin output enables |
| pinAltValid | output | NUM_PINS | Pin is in an alternate function |
| pinAltIdx | output | 3*NUM_PINS | Alternate index for each pin, pin p at bits 3p+2:3p |

## Verification
The bench builds the block with its defaults: 54 pins and a 6-bit word address. With 54 pins the top select word is only partly populated, and bank 1 is only 22 bits wide. The padding rules and the ignored set and clear bits above pin 53 can therefore be observed at the ports. The 6-bit address reaches every unmapped word up to 63, so reads and writes there can be checked as well. Randomised traffic mixes reads, writes and changing pin levels. This brings in reads in the same cycle as a write, set and clear of the same pin in consecutive cycles, and function changes on pins that are currently driven.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WORD_W       = 32;
  localparam int FIELD_W      = 3;
  localparam int PINS_PER_SEL = 10;
  localparam int SET_WORD     = 7;
  localparam int CLR_WORD     = 10;
  localparam int LEV_WORD     = 13;

  typedef enum logic [FIELD_W-1:0] {
    FN_INPUT  = 3'b000,
    FN_OUTPUT = 3'b001,
    FN_ALT5   = 3'b010,
    FN_ALT4   = 3'b011,
    FN_ALT0   = 3'b100,
    FN_ALT1   = 3'b101,
    FN_ALT2   = 3'b110,
    FN_ALT3   = 3'b111
  } pinFunc_e;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_SEL   = 2'd1,
    RD_LEVEL = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic       selWr;
    logic       setWr;
    logic       clrWr;
    logic       rdLoad;
    rdSrc_e     rdSrc;
    logic [3:0] wordIdx;
    logic       bankHi;
  } regStrobes_t;
endpackage

// File: rtl/gpio_pinmux_ctrl.sv
module gpio_pinmux_ctrl
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobes_t       strobes
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NUM_SEL_WORDS = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;

  logic [31:0] addrWide;
  assign addrWide = 32'(busAddr);

  always_comb begin
    strobes        = '0;
    strobes.rdLoad = busRdEn;
    strobes.rdSrc  = RD_ZERO;
    if (addrWide < 32'(NUM_SEL_WORDS)) begin
      strobes.selWr   = busWrEn;
      strobes.rdSrc   = RD_SEL;
      strobes.wordIdx = 4'(addrWide);
    end else if (addrWide == 32'(SET_WORD) || addrWide == 32'(SET_WORD + 1)) begin
      strobes.setWr  = busWrEn;
      strobes.bankHi = (addrWide == 32'(SET_WORD + 1));
    end else if (addrWide == 32'(CLR_WORD) || addrWide == 32'(CLR_WORD + 1)) begin
      strobes.clrWr  = busWrEn;
      strobes.bankHi = (addrWide == 32'(CLR_WORD + 1));
    end else if (addrWide == 32'(LEV_WORD) || addrWide == 32'(LEV_WORD + 1)) begin
      strobes.rdSrc  = RD_LEVEL;
      strobes.bankHi = (addrWide == 32'(LEV_WORD + 1));
    end
  end
endmodule

// File: rtl/gpio_fn_decode.sv
module gpio_fn_decode
  import gpio_pinmux_pkg::*;
(
  input  logic [FIELD_W-1:0] fnCode,
  output logic               outEn,
  output logic               altValid,
  output logic [FIELD_W-1:0] altIdx
);
  timeunit 1ns;
  timeprecision 100ps;

  always_comb begin
    outEn    = 1'b0;
    altValid = 1'b1;
    altIdx   = '0;
    unique case (pinFunc_e'(fnCode))
      FN_INPUT:  altValid = 1'b0;
      FN_OUTPUT: begin
        altValid = 1'b0;
        outEn    = 1'b1;
      end
      FN_ALT0:   altIdx = 3'd0;
      FN_ALT1:   altIdx = 3'd1;
      FN_ALT2:   altIdx = 3'd2;
      FN_ALT3:   altIdx = 3'd3;
      FN_ALT4:   altIdx = 3'd4;
      FN_ALT5:   altIdx = 3'd5;
      default:   altValid = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_pinmux_dp.sv
module gpio_pinmux_dp
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 54
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regStrobes_t                 strobes,
  input  logic [WORD_W-1:0]           wrData,
  input  logic [NUM_PINS-1:0]         pinIn,
  output logic [WORD_W-1:0]           rdData,
  output logic [NUM_PINS-1:0]         pinOut,
  output logic [NUM_PINS-1:0]         pinOe,
  output logic [NUM_PINS-1:0]         pinAltValid,
  output logic [FIELD_W*NUM_PINS-1:0] pinAltIdx
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NUM_SEL_WORDS = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;
  localparam int PAD_W         = 2 * WORD_W;
  localparam int FIELDS_W      = FIELD_W * PINS_PER_SEL;

  logic [FIELD_W*NUM_PINS-1:0]                selFlat;
  logic [NUM_SEL_WORDS-1:0][WORD_W-1:0]       selWords;
  logic [NUM_PINS-1:0]                        outReg;
  logic [NUM_PINS-1:0]                        pinMask;
  logic [NUM_PINS-1:0]                        syncA;
  logic [NUM_PINS-1:0]                        syncB;
  logic [PAD_W-1:0]                           levPad;
  logic [WORD_W-1:0]                          rdNext;

  // function select storage: one write updates the ten fields of a word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selFlat <= '0;
    end else if (strobes.selWr) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (strobes.wordIdx == 4'(p / PINS_PER_SEL)) begin
          selFlat[FIELD_W*p +: FIELD_W] <= wrData[FIELD_W*(p % PINS_PER_SEL) +: FIELD_W];
        end
      end
    end
  end

  // per-pin function decode
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_fn_decode u_dec (
      .fnCode   (selFlat[FIELD_W*p +: FIELD_W]),
      .outEn    (pinOe[p]),
      .altValid (pinAltValid[p]),
      .altIdx   (pinAltIdx[FIELD_W*p +: FIELD_W])
    );
  end

  // readback words with zero padding above the last pin and above bit 29
  for (genvar w = 0; w < NUM_SEL_WORDS; w++) begin : g_word
    for (genvar i = 0; i < PINS_PER_SEL; i++) begin : g_slot
      if (w * PINS_PER_SEL + i < NUM_PINS) begin : g_live
        assign selWords[w][FIELD_W*i +: FIELD_W] =
          selFlat[FIELD_W*(w*PINS_PER_SEL + i) +: FIELD_W];
      end else begin : g_pad
        assign selWords[w][FIELD_W*i +: FIELD_W] = '0;
      end
    end
    assign selWords[w][WORD_W-1:FIELDS_W] = '0;
  end

  // bank-relative mask for the set and clear words
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      pinMask[p] = wrData[p % WORD_W] && (strobes.bankHi == (p >= WORD_W));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strobes.clrWr) begin
      outReg <= outReg & ~pinMask;
    end else if (strobes.setWr) begin
      outReg <= outReg | pinMask;
    end
  end

  assign pinOut = outReg;

  // two-flop input synchroniser
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  assign levPad = PAD_W'(syncB);

  always_comb begin
    rdNext = '0;
    unique case (strobes.rdSrc)
      RD_SEL: begin
        for (int w = 0; w < NUM_SEL_WORDS; w++) begin
          if (strobes.wordIdx == 4'(w)) rdNext = selWords[w];
        end
      end
      RD_LEVEL: rdNext = strobes.bankHi ? levPad[PAD_W-1:WORD_W] : levPad[WORD_W-1:0];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.rdLoad) begin
      rdData <= rdNext;
    end
  end
endmodule

// File: rtl/gpio_pinmux_regs.sv
module gpio_pinmux_regs
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWrEn,
  input  logic [31:0]                 busWrData,
  input  logic                        busRdEn,
  output logic [31:0]                 busRdData,
  input  logic [NUM_PINS-1:0]         pinIn,
  output logic [NUM_PINS-1:0]         pinOut,
  output logic [NUM_PINS-1:0]         pinOe,
  output logic [NUM_PINS-1:0]         pinAltValid,
  output logic [3*NUM_PINS-1:0]       pinAltIdx
);
  timeunit 1ns;
  timeprecision 100ps;

  regStrobes_t strobes;

  gpio_pinmux_ctrl #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  gpio_pinmux_dp #(
    .NUM_PINS (NUM_PINS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (busWrData),
    .pinIn       (pinIn),
    .rdData      (busRdData),
    .pinOut      (pinOut),
    .pinOe       (pinOe),
    .pinAltValid (pinAltValid),
    .pinAltIdx   (pinAltIdx)
  );
endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk #(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [2:0]          wrLow,
  input logic                busRdEn,
  input logic [31:0]         busRdData,
  input logic                pin0In,
  input logic [NUM_PINS-1:0] pinOut,
  input logic                pin0Oe,
  input logic                pin0AltValid
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [2:0] upCycles;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCycles <= '0;
    else if (upCycles != 3'd7) upCycles <= upCycles + 3'd1;
  end

  logic wrSel0, wrSet0, wrClr0, outWrite;
  assign wrSel0   = busWrEn && (busAddr == ADDR_W'(0));
  assign wrSet0   = busWrEn && (busAddr == ADDR_W'(7));
  assign wrClr0   = busWrEn && (busAddr == ADDR_W'(10));
  assign outWrite = busWrEn && (busAddr == ADDR_W'(7) || busAddr == ADDR_W'(8) ||
                                busAddr == ADDR_W'(10) || busAddr == ADDR_W'(11));

  assert_oe_follows_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrSel0 |=> pin0Oe == ($past(wrLow) == 3'b001));

  assert_alt_follows_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrSel0 |=> pin0AltValid == ($past(wrLow) >= 3'd2));

  assert_set_drives_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrSet0 && wrLow[0]) |=> pinOut[0]);

  assert_clr_drives_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr0 && wrLow[0]) |=> !pinOut[0]);

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outWrite |=> $stable(pinOut));

  assert_strobe_read_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && (busAddr == ADDR_W'(7) || busAddr == ADDR_W'(8) ||
                 busAddr == ADDR_W'(10) || busAddr == ADDR_W'(11))) |=> busRdData == 32'd0);

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr >= ADDR_W'(15)) |=> busRdData == 32'd0);

  assert_level_sync_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(13) && upCycles >= 3'd4) |=> busRdData[0] == $past(pin0In, 3));
endmodule

bind gpio_pinmux_regs gpio_pinmux_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busAddr      (busAddr),
  .busWrEn      (busWrEn),
  .wrLow        (busWrData[2:0]),
  .busRdEn      (busRdEn),
  .busRdData    (busRdData),
  .pin0In       (pinIn[0]),
  .pinOut       (pinOut),
  .pin0Oe       (pinOe[0]),
  .pin0AltValid (pinAltValid[0])
);

// File: tb/tb_gpio_pinmux_regs.sv
module tb_gpio_pinmux_regs;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NUM_PINS = 54;
  localparam int ADDR_W   = 6;
  localparam int NSEL     = 6;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [ADDR_W-1:0]      busAddr = '0;
  logic                   busWrEn = 1'b0;
  logic [31:0]            busWrData = '0;
  logic                   busRdEn = 1'b0;
  logic [31:0]            busRdData;
  logic [NUM_PINS-1:0]    pinIn = '0;
  logic [NUM_PINS-1:0]    pinOut;
  logic [NUM_PINS-1:0]    pinOe;
  logic [NUM_PINS-1:0]    pinAltValid;
  logic [3*NUM_PINS-1:0]  pinAltIdx;

  always #2.5 clk = ~clk;

  gpio_pinmux_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .pinAltValid(pinAltValid), .pinAltIdx(pinAltIdx)
  );

  // behavioural reference state
  int              mSel [NUM_PINS];
  bit [63:0]       mOut, mS1, mS2;
  bit [31:0]       mRd;
  string           mRdTag = "R1";
  int              compared = 0;
  int              mismatched = 0;
  bit              finished = 0;

  function automatic int altOf(int code);
    case (code)
      4: return 0;
      5: return 1;
      6: return 2;
      7: return 3;
      3: return 4;
      2: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mSel[i]) mSel[i] = 0;
      mOut = 0; mS1 = 0; mS2 = 0; mRd = 0; mRdTag = "R1";
    end else begin
      int a;
      a = int'(busAddr);
      if (busRdEn) begin
        mRd = 0;
        if (a < NSEL) begin
          for (int i = 0; i < 10; i++)
            if (a * 10 + i < NUM_PINS) mRd = mRd | (32'(mSel[a*10+i]) << (3 * i));
          mRdTag = (a == NSEL - 1) ? "R2/R9 select readback" : "R2 select readback";
        end else if (a == 7 || a == 8 || a == 10 || a == 11) begin
          mRdTag = "R7 set/clear readback";
        end else if (a == 13) begin
          mRd = mS2[31:0];
          mRdTag = "R8 level bank0";
        end else if (a == 14) begin
          mRd = mS2[63:32];
          mRdTag = "R8/R9 level bank1";
        end else begin
          mRdTag = "R10 unmapped readback";
        end
      end
      if (busWrEn) begin
        if (a < NSEL) begin
          for (int i = 0; i < 10; i++)
            if (a * 10 + i < NUM_PINS) mSel[a*10+i] = int'((busWrData >> (3 * i)) & 32'h7);
        end else if (a == 7) mOut[31:0]  = mOut[31:0] | busWrData;
        else if (a == 8)     mOut[63:32] = mOut[63:32] | busWrData;
        else if (a == 10)    mOut[31:0]  = mOut[31:0] & ~busWrData;
        else if (a == 11)    mOut[63:32] = mOut[63:32] & ~busWrData;
        mOut = mOut & ((64'd1 << NUM_PINS) - 64'd1);
      end
      mS2 = mS1;
      mS1 = 64'(pinIn);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      logic [NUM_PINS-1:0]   eOe, eAv;
      logic [3*NUM_PINS-1:0] eIdx;
      eOe = '0; eAv = '0; eIdx = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
        eOe[p] = (mSel[p] == 1);
        if (altOf(mSel[p]) >= 0) begin
          eAv[p] = 1'b1;
          eIdx[3*p +: 3] = 3'(altOf(mSel[p]));
        end
      end
      check(mRdTag, 64'(busRdData), 64'(mRd));
      check("R5/R6/R9/R10/R11 pin outputs", 64'(pinOut), mOut);
      check("R3/R10 output enables", 64'(pinOe), 64'(eOe));
      check("R4/R10 alternate valid", 64'(pinAltValid), 64'(eAv));
      check("R4 alternate index", pinAltIdx[63:0], eIdx[63:0]);
      check("R4 alternate index upper", 64'(pinAltIdx[3*NUM_PINS-1:64]), 64'(eIdx[3*NUM_PINS-1:64]));
    end
  end

  task automatic drive(bit we, bit re, int addr, logic [31:0] data);
    @(negedge clk);
    busWrEn   = we;
    busRdEn   = re;
    busAddr   = ADDR_W'(addr);
    busWrData = data;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 32'd0);
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog (all requirements) actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] w;
    #1;
    // R1: reset state observed before any clock edge
    check("R1 reset pinOut", 64'(pinOut), 64'd0);
    check("R1 reset pinOe", 64'(pinOe), 64'd0);
    check("R1 reset rdData", 64'(busRdData), 64'd0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R2/R4: every code on pins 0..9
    w = 0;
    for (int i = 0; i < 10; i++) w = w | (32'(i % 8) << (3 * i));
    drive(1, 0, 0, w | 32'hC000_0000);
    drive(0, 1, 0, 32'd0);
    // R3: word 1 all outputs
    w = 0;
    for (int i = 0; i < 10; i++) w = w | (32'd1 << (3 * i));
    drive(1, 1, 1, w);          // read returns the pre-write value
    drive(0, 1, 1, 32'd0);
    drive(1, 0, 2, 32'h2DB6_DB6D);
    drive(1, 0, 3, 32'h1234_5678);
    drive(1, 0, 4, 32'h0FED_CBA9);
    // R9: top word partly populated
    drive(1, 0, 5, 32'hFFFF_FFFF);
    for (int a = 0; a < NSEL; a++) drive(0, 1, a, 32'd0);

    // R5/R6/R7/R9: set and clear
    drive(1, 0, 7, 32'hA5A5_A5A5);
    drive(1, 0, 7, 32'd0);
    drive(1, 0, 10, 32'h0000_00F0);
    drive(1, 0, 8, 32'hFFFF_FFFF);
    drive(1, 0, 11, 32'h0000_0003);
    drive(1, 0, 10, 32'd0);
    for (int a = 7; a <= 11; a++) drive(0, 1, a, 32'd0);

    // R11: function change leaves the outputs alone
    drive(1, 0, 0, 32'd0);
    drive(1, 0, 0, 32'h3FFF_FFFF);

    // R10: unmapped words
    foreach (w[i]) begin end
    drive(1, 1, 6, 32'hFFFF_FFFF);
    drive(1, 1, 9, 32'hFFFF_FFFF);
    drive(1, 1, 12, 32'hFFFF_FFFF);
    drive(1, 1, 15, 32'hFFFF_FFFF);
    drive(1, 1, 40, 32'hFFFF_FFFF);
    drive(1, 1, 63, 32'hFFFF_FFFF);

    // R8: level words through the synchroniser
    pinIn = {22'h2AAAAA, 32'h5555_AAAA};
    drive(0, 1, 13, 32'd0);
    drive(0, 1, 13, 32'd0);
    drive(0, 1, 14, 32'd0);
    idle(3);
    drive(0, 1, 13, 32'd0);
    drive(0, 1, 14, 32'd0);

    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      int a;
      a = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 63)) : int'($urandom_range(0, 15));
      pinIn = NUM_PINS'({$urandom(), $urandom()});
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom());
    end
    idle(4);
    summary();
  end
endmodule